// File: doc/BRIEF.md
# ALU with status flags

A 16-bit combinational arithmetic and logic unit for a small register-based processor, together with the logic that works out the next value of the processor's flag register. Each cycle the surrounding datapath presents two operands, a 16-bit immediate that supplies the shift amount, an operation code and the current flag register. The block returns the result, the flag register to be written back and a strobe that says whether the result should be written to the destination register.

Flag rules depend on the operation. Addition, subtraction, negation, increment and decrement share one carry-propagate adder and differ only in how its operands are formed and how its carry is read. The bitwise operations update only zero and negative. Increment and decrement never change carry. A shift whose amount is zero touches nothing. Compare and test set flags exactly as subtract and AND do, but they suppress the result write.

The block has no clock and no state. Its control is a single decode stage that sorts each operation code into one of four result sources (none, adder, bitwise unit, shifter) and sets a keep-or-update rule for each flag group. The listed codes are the only transitions. Codes 13 to 15 fall into the "none" source.

Top module: `alu_flags_unit`

## Requirements
- R1: The flag layout is Z in bit 0, N in bit 1, C in bit 2, V in bit 3 and I in bit 4. Bits 15..5 of flags_out are always 0. For every op_sel, flags_out bit 4 equals flags_in bit 4.
- R2: Every operation that updates flags sets Z to 1 exactly when the 16-bit result is zero, and sets N to result bit 15. Shifts by zero and unknown codes do not update flags.
- R3: ADD (op_sel 0) gives result = (a + b) mod 2^16. C is 1 when the unsigned sum exceeds 0xFFFF. V is 1 when a and b share a sign that differs from the sign of the result. wr_en is 1.
- R4: SUB (op_sel 1) gives result = (a - b) mod 2^16. C is the borrow, 1 exactly when a < b unsigned. V is 1 when a and b differ in sign and the result's sign differs from a. wr_en is 1.
- R5: AND (op_sel 2), OR (3), XOR (4) and NOT (5, result = ~a) produce the bitwise result with wr_en 1. C and V keep their values from flags_in.
- R6: NEG (op_sel 6) gives result = (0 - a) mod 2^16. C is 1 when a is nonzero. V is 1 only when a is 0x8000. wr_en is 1.
- R7: INC (op_sel 7) gives a + 1 and DEC (op_sel 8) gives a - 1, both mod 2^16, with wr_en 1. C keeps its value from flags_in. V is 1 only when a is 0x7FFF for INC, or 0x8000 for DEC.
- R8: SHL (op_sel 9) and SHR (op_sel 10) shift a logically by n = imm_val[3:0]. For n != 0, C receives the last bit shifted out: a[16-n] for SHL, a[n-1] for SHR. V keeps its value. wr_en is 1.
- R9: For SHL or SHR with imm_val[3:0] = 0, the result equals a and flags_out[4:0] equals flags_in[4:0], even when higher imm_val bits are set. wr_en is 1.
- R10: CMP (op_sel 11) sets flags as SUB does, and TEST (op_sel 12) sets flags as AND does. For both, wr_en is 0 and result shows the computed difference or conjunction.
- R11: An op_sel of 13, 14 or 15 gives result 0, wr_en 0 and flags_out[4:0] equal to flags_in[4:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | First operand; the only operand for NOT, NEG, INC, DEC and shifts |
| opnd_b | input | 16 | Second operand |
| imm_val | input | 16 | Immediate; low four bits are the shift amount |
| flags_in | input | 16 | Current flag register |
| result | output | 16 | Operation result |
| flags_out | output | 16 | Next flag register value |
| wr_en | output | 1 | Result should be written to the destination register |

## Verification
The hardest cases to reach are the exact boundary operands, where a single operand value flips a flag. These are INC of 0x7FFF, DEC and NEG of 0x8000, NEG of zero, and shifts whose amount nibble is zero while the upper immediate bits are not. Uniform random operands almost never land on them. The stimulus therefore runs each boundary as a directed case first. The random phase then takes operands from a small pool of sign-boundary values a good share of the time, and forces the amount nibble to zero for one shift in four. Random flag inputs with C and V set make sure that "keep" rules cannot pass by accident on zeroes.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_NEG  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_CMP  = 4'd11,
        OP_TEST = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        AR_ADD,
        AR_SUB,
        AR_NEG,
        AR_INC,
        AR_DEC
    } arith_mode_e;

    typedef enum logic [1:0] {
        BW_AND,
        BW_OR,
        BW_XOR,
        BW_NOT
    } bitw_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ARITH,
        SRC_BITW,
        SRC_SHIFT
    } res_src_e;

    typedef enum logic [1:0] {
        CR_KEEP,
        CR_ARITH,
        CR_SHIFT
    } carry_rule_e;

    localparam int FLG_Z    = 0;
    localparam int FLG_N    = 1;
    localparam int FLG_C    = 2;
    localparam int FLG_V    = 3;
    localparam int FLG_I    = 4;
    localparam int FLG_LIVE = 5;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  arith_mode_e       mode,
    output logic [DATA_W-1:0] sum,
    output logic              c_flag,
    output logic              v_flag
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x_op;
    logic [DATA_W-1:0] y_op;
    logic              cin;
    logic [DATA_W:0]   wide;

    // Operand shaping: every mode becomes x + y + cin
    always_comb begin
        x_op = a;
        y_op = b;
        cin  = 1'b0;
        unique case (mode)
            AR_ADD: begin x_op = a;  y_op = b;   cin = 1'b0; end
            AR_SUB: begin x_op = a;  y_op = ~b;  cin = 1'b1; end
            AR_NEG: begin x_op = '0; y_op = ~a;  cin = 1'b1; end
            AR_INC: begin x_op = a;  y_op = '0;  cin = 1'b1; end
            AR_DEC: begin x_op = a;  y_op = '1;  cin = 1'b0; end
            default: begin x_op = a; y_op = b;   cin = 1'b0; end
        endcase
    end

    assign wide = {1'b0, x_op} + {1'b0, y_op} + {{DATA_W{1'b0}}, cin};
    assign sum  = wide[DATA_W-1:0];

    // Addition reports carry; subtraction forms report borrow
    assign c_flag = (mode == AR_ADD) ? wide[DATA_W] : ~wide[DATA_W];
    assign v_flag = (x_op[MSB] ^ sum[MSB]) & (y_op[MSB] ^ sum[MSB]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  bitw_mode_e        mode,
    output logic [DATA_W-1:0] y
);

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        always_comb begin
            unique case (mode)
                BW_AND:  y[g] = a[g] & b[g];
                BW_OR:   y[g] = a[g] | b[g];
                BW_XOR:  y[g] = a[g] ^ b[g];
                BW_NOT:  y[g] = ~a[g];
                default: y[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   amt,
    input  logic              go_left,
    output logic [DATA_W-1:0] y,
    output logic              c_last,
    output logic              active
);

    logic [DATA_W:0] l_ext;
    logic [DATA_W:0] r_ext;

    // One spare bit beside the operand catches the last bit moved out
    assign l_ext  = {1'b0, a} << amt;
    assign r_ext  = {a, 1'b0} >> amt;
    assign active = (amt != '0);

    always_comb begin
        if (!active) begin
            y      = a;
            c_last = 1'b0;
        end else if (go_left) begin
            y      = l_ext[DATA_W-1:0];
            c_last = l_ext[DATA_W];
        end else begin
            y      = r_ext[DATA_W:1];
            c_last = r_ext[0];
        end
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 16,
    parameter int OP_W   = 4
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              wr_en
);

    localparam int SH_W = $clog2(DATA_W);
    localparam int MSB  = DATA_W - 1;

    // Decode controls
    res_src_e    src;
    arith_mode_e ar_mode;
    bitw_mode_e  bw_mode;
    logic        go_left;
    logic        wr_d;
    logic        upd_zn;
    carry_rule_e c_rule;
    logic        upd_v;

    // Unit outputs
    logic [DATA_W-1:0] ar_sum;
    logic              ar_c;
    logic              ar_v;
    logic [DATA_W-1:0] bw_y;
    logic [DATA_W-1:0] sh_y;
    logic              sh_c;
    logic              sh_active;

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (opnd_a),
        .b      (opnd_b),
        .mode   (ar_mode),
        .sum    (ar_sum),
        .c_flag (ar_c),
        .v_flag (ar_v)
    );

    alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a    (opnd_a),
        .b    (opnd_b),
        .mode (bw_mode),
        .y    (bw_y)
    );

    alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shifter (
        .a       (opnd_a),
        .amt     (imm_val[SH_W-1:0]),
        .go_left (go_left),
        .y       (sh_y),
        .c_last  (sh_c),
        .active  (sh_active)
    );

    // Decode: operation code to source and flag rules
    always_comb begin
        src     = SRC_NONE;
        ar_mode = AR_ADD;
        bw_mode = BW_AND;
        go_left = 1'b0;
        wr_d    = 1'b1;
        upd_zn  = 1'b1;
        c_rule  = CR_KEEP;
        upd_v   = 1'b0;
        unique case (alu_op_e'(op_sel))
            OP_ADD:  begin src = SRC_ARITH; ar_mode = AR_ADD; c_rule = CR_ARITH; upd_v = 1'b1; end
            OP_SUB:  begin src = SRC_ARITH; ar_mode = AR_SUB; c_rule = CR_ARITH; upd_v = 1'b1; end
            OP_CMP:  begin src = SRC_ARITH; ar_mode = AR_SUB; c_rule = CR_ARITH; upd_v = 1'b1;
                           wr_d = 1'b0; end
            OP_NEG:  begin src = SRC_ARITH; ar_mode = AR_NEG; c_rule = CR_ARITH; upd_v = 1'b1; end
            OP_INC:  begin src = SRC_ARITH; ar_mode = AR_INC; upd_v = 1'b1; end
            OP_DEC:  begin src = SRC_ARITH; ar_mode = AR_DEC; upd_v = 1'b1; end
            OP_AND:  begin src = SRC_BITW;  bw_mode = BW_AND; end
            OP_TEST: begin src = SRC_BITW;  bw_mode = BW_AND; wr_d = 1'b0; end
            OP_OR:   begin src = SRC_BITW;  bw_mode = BW_OR;  end
            OP_XOR:  begin src = SRC_BITW;  bw_mode = BW_XOR; end
            OP_NOT:  begin src = SRC_BITW;  bw_mode = BW_NOT; end
            OP_SHL:  begin src = SRC_SHIFT; go_left = 1'b1;
                           upd_zn = sh_active; c_rule = sh_active ? CR_SHIFT : CR_KEEP; end
            OP_SHR:  begin src = SRC_SHIFT; go_left = 1'b0;
                           upd_zn = sh_active; c_rule = sh_active ? CR_SHIFT : CR_KEEP; end
            default: begin src = SRC_NONE;  wr_d = 1'b0; upd_zn = 1'b0; end
        endcase
    end

    // Outputs: result mux and next flag register
    always_comb begin
        unique case (src)
            SRC_ARITH: result = ar_sum;
            SRC_BITW:  result = bw_y;
            SRC_SHIFT: result = sh_y;
            default:   result = '0;
        endcase

        flags_out        = '0;
        flags_out[FLG_I] = flags_in[FLG_I];
        flags_out[FLG_Z] = upd_zn ? (result == '0) : flags_in[FLG_Z];
        flags_out[FLG_N] = upd_zn ? result[MSB]    : flags_in[FLG_N];
        unique case (c_rule)
            CR_ARITH: flags_out[FLG_C] = ar_c;
            CR_SHIFT: flags_out[FLG_C] = sh_c;
            default:  flags_out[FLG_C] = flags_in[FLG_C];
        endcase
        flags_out[FLG_V] = upd_v ? ar_v : flags_in[FLG_V];

        wr_en = wr_d;
    end

endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 16,
    parameter int OP_W   = 4
) (
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] imm_val,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags_out,
    input logic              wr_en
);

    localparam logic [FLAG_W-1:0] LIVE_MASK = FLAG_W'((1 << FLG_LIVE) - 1);
    localparam logic [DATA_W-1:0] AMT_MASK  = DATA_W'(DATA_W - 1);

    logic is_shift;
    logic amt_zero;
    logic flags_same;
    logic [DATA_W:0] add_ref;

    assign is_shift   = (op_sel == OP_W'(OP_SHL)) || (op_sel == OP_W'(OP_SHR));
    assign amt_zero   = ((imm_val & AMT_MASK) == '0);
    assign flags_same = (((flags_out ^ flags_in) & LIVE_MASK) == '0);
    assign add_ref    = {1'b0, opnd_a} + {1'b0, opnd_b};

    always_comb begin
        assert_i_passthru_R1: assert (flags_out[FLG_I] == flags_in[FLG_I]);

        if (wr_en && !(is_shift && amt_zero))
            assert_zero_flag_R2: assert (flags_out[FLG_Z] == (result == '0));

        if (op_sel == OP_W'(OP_ADD))
            assert_add_sum_R3: assert ({flags_out[FLG_C], result} == add_ref);

        if (op_sel == OP_W'(OP_SUB))
            assert_sub_borrow_R4: assert (flags_out[FLG_C] == (opnd_a < opnd_b));

        if (op_sel >= OP_W'(OP_AND) && op_sel <= OP_W'(OP_NOT))
            assert_bitw_keep_cv_R5: assert (flags_out[FLG_V:FLG_C] == flags_in[FLG_V:FLG_C]);

        if (op_sel == OP_W'(OP_NEG))
            assert_neg_sum_R6: assert (DATA_W'(result + opnd_a) == '0);

        if (op_sel == OP_W'(OP_INC) || op_sel == OP_W'(OP_DEC))
            assert_incdec_keep_c_R7: assert (flags_out[FLG_C] == flags_in[FLG_C]);

        if (is_shift && amt_zero)
            assert_shift_zero_R9: assert (flags_same && result == opnd_a);

        if (op_sel == OP_W'(OP_CMP) || op_sel == OP_W'(OP_TEST))
            assert_no_write_R10: assert (!wr_en);

        if (op_sel > OP_W'(OP_TEST))
            assert_bad_op_R11: assert (!wr_en && result == '0 && flags_same);
    end

endmodule

bind alu_flags_unit alu_flags_unit_chk #(
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W),
    .OP_W   (OP_W)
) chk_i (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm_val   (imm_val),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/alu_flags_unit_tb_top.sv
module alu_flags_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic [3:0]  op_sel;
    logic [15:0] opnd_a, opnd_b, imm_val, flags_in;
    logic [15:0] result, flags_out;
    logic        wr_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flags_unit dut_i (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .imm_val   (imm_val),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .wr_en     (wr_en)
    );

    // Independent reference: {wr, flags, result}
    function automatic logic [32:0] model(input logic [3:0] op, input logic [15:0] a,
                                          input logic [15:0] b, input logic [15:0] imm,
                                          input logic [15:0] fi);
        logic [15:0] r;
        logic [16:0] full;
        logic c, v, wr, upd;
        int n;
        c = fi[2]; v = fi[3]; wr = 1'b1; upd = 1'b1; r = '0;
        n = int'(imm[3:0]);
        case (op)
            4'd0: begin full = {1'b0, a} + {1'b0, b}; r = full[15:0]; c = full[16];
                        v = (a[15] == b[15]) && (r[15] != a[15]); end
            4'd1, 4'd11: begin r = a - b; c = (a < b);
                        v = (a[15] != b[15]) && (r[15] != a[15]); wr = (op == 4'd1); end
            4'd2, 4'd12: begin r = a & b; wr = (op == 4'd2); end
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = ~a;
            4'd6: begin r = 16'd0 - a; c = (a != 16'd0); v = (a == 16'h8000); end
            4'd7: begin r = a + 16'd1; v = (a == 16'h7fff); end
            4'd8: begin r = a - 16'd1; v = (a == 16'h8000); end
            4'd9: if (n == 0) begin r = a; upd = 1'b0; end
                  else begin r = a << n; c = a[16-n]; end
            4'd10: if (n == 0) begin r = a; upd = 1'b0; end
                   else begin r = a >> n; c = a[n-1]; end
            default: begin r = '0; wr = 1'b0; upd = 1'b0; end
        endcase
        return {wr, upd ? {11'd0, fi[4], v, c, r[15], (r == 16'd0)} : {11'd0, fi[4:0]}, r};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3, 4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            4'd9, 4'd10: return "R8";
            4'd11, 4'd12: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic run_check(input string tag, input logic [3:0] op, input logic [15:0] a,
                             input logic [15:0] b, input logic [15:0] imm, input logic [15:0] fi);
        logic [32:0] exp_v;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm_val = imm; flags_in = fi;
        @(posedge clk);
        #(CLK_PERIOD/4);
        exp_v = model(op, a, b, imm, fi);
        total++;
        if ({wr_en, flags_out, result} !== exp_v) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h fin=%h : got res=%h flg=%h wr=%b exp res=%h flg=%h wr=%b",
                     tag, op, a, b, imm, fi, result, flags_out, wr_en,
                     exp_v[15:0], exp_v[31:16], exp_v[32]);
        end
    endtask

    function automatic logic [15:0] pick_operand();
        logic [15:0] pool [6];
        pool[0] = 16'h0000; pool[1] = 16'h0001; pool[2] = 16'h7fff;
        pool[3] = 16'h8000; pool[4] = 16'hffff; pool[5] = 16'h8001;
        if (($urandom % 8) < 3) return pool[$urandom % 6];
        return 16'($urandom);
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd424242));
        op_sel = '0; opnd_a = '0; opnd_b = '0; imm_val = '0; flags_in = '0;

        // Idle-input state: zero add gives zero result with Z set (R2)
        run_check("R2", 4'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        // R1: upper flag bits cleared, I copied
        run_check("R1", 4'd3, 16'h1234, 16'h0000, 16'h0000, 16'hffff);
        run_check("R1", 4'd1, 16'h0005, 16'h0003, 16'h0000, 16'h0010);
        // R3: signed overflow, unsigned carry to zero
        run_check("R3", 4'd0, 16'h7fff, 16'h0001, 16'h0000, 16'h0000);
        run_check("R3", 4'd0, 16'hffff, 16'h0001, 16'h0000, 16'h0000);
        // R4: borrow and overflow
        run_check("R4", 4'd1, 16'h0000, 16'h0001, 16'h0000, 16'h0000);
        run_check("R4", 4'd1, 16'h8000, 16'h0001, 16'h0000, 16'h0000);
        // R5: C and V held high through logic ops
        run_check("R5", 4'd2, 16'hf0f0, 16'h0f0f, 16'h0000, 16'h000c);
        run_check("R5", 4'd5, 16'h00ff, 16'h0000, 16'h0000, 16'h0008);
        // R6: negation corners
        run_check("R6", 4'd6, 16'h0000, 16'h0000, 16'h0000, 16'h000f);
        run_check("R6", 4'd6, 16'h8000, 16'h0000, 16'h0000, 16'h0000);
        // R7: INC/DEC overflow boundaries with C preset
        run_check("R7", 4'd7, 16'h7fff, 16'h0000, 16'h0000, 16'h0004);
        run_check("R7", 4'd8, 16'h8000, 16'h0000, 16'h0000, 16'h0000);
        run_check("R7", 4'd7, 16'hffff, 16'h0000, 16'h0000, 16'h0000);
        // R8: last-bit-out carry
        run_check("R8", 4'd9, 16'h8001, 16'h0000, 16'h0001, 16'h0000);
        run_check("R8", 4'd10, 16'h0003, 16'h0000, 16'h0001, 16'h0000);
        run_check("R8", 4'd9, 16'h0003, 16'h0000, 16'h000f, 16'h0008);
        // R9: zero amount with upper immediate bits set
        run_check("R9", 4'd9, 16'h0000, 16'h0000, 16'h0010, 16'h001f);
        run_check("R9", 4'd10, 16'h8421, 16'h0000, 16'hfff0, 16'h0000);
        // R10: compare and test, no write
        run_check("R10", 4'd11, 16'h1234, 16'h1234, 16'h0000, 16'h0000);
        run_check("R10", 4'd12, 16'h8000, 16'h8001, 16'h0000, 16'h000c);
        // R11: unused codes
        run_check("R11", 4'd14, 16'hffff, 16'hffff, 16'h0000, 16'h0015);
        run_check("R11", 4'd13, 16'h0001, 16'h0001, 16'h0000, 16'h000a);

        for (int k = 0; k < N_RANDOM; k++) begin
            logic [3:0]  rop;
            logic [15:0] rimm;
            rop  = 4'($urandom % 16);
            rimm = 16'($urandom);
            if (($urandom % 4) == 0) rimm[3:0] = 4'd0;
            run_check(tag_of(rop), rop, pick_operand(), pick_operand(), rimm, 16'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule